// File: doc/BRIEF.md
# Update-Protocol Coherence Controller for One Cache Line

This block keeps the coherence state of a single cache line in a multiprocessor where writes to shared data are broadcast as word updates instead of invalidating other copies. The protocol has no invalid state: the line carries no coherence state until a fill loads it, and from then on it is always in one of four states. These are Exclusive (clean, sole copy), Shared-Clean, Shared-Modified (possibly dirty, this cache must supply the block) and Modified (dirty, sole copy). A separate valid flag marks whether a block has been loaded at all.

The controller takes processor read hits, write hits and read misses, a fill strobe that marks a newly loaded block, and snooped bus transactions. It samples a wired copies-exist line and issues bus read, bus update and flush commands. When a snooped update hits a shared copy, the controller drives a write-enable strobe and the broadcast word towards the data array. Next state and commands are decided in the same cycle from the current state and inputs, and the state register updates on the following clock edge.

Encodings used at the ports: line state Exclusive=0, Shared-Clean=1, Shared-Modified=2, Modified=3. Bus and snoop command: 0 none, 1 bus read, 2 bus update, 3 flush.

Top module: `dragon_line_ctrl`

## Requirements
- R1: After reset `line_valid` is 0, `bus_cmd` is 0 and `upd_we` is 0. While the line is not loaded, snoops and processor hits issue no command, raise no `upd_we` and leave `line_valid` at 0.
- R2: `cpu_rd_miss` drives `bus_cmd`=1 (bus read) in that cycle and leaves the state unchanged. No other input causes a bus read.
- R3: A fill with `fill_wr`=0 sets `line_valid` and loads Exclusive (0) when `copies_exist` is 0, or Shared-Clean (1) when it is 1, issuing no command.
- R4: A fill with `fill_wr`=1 loads Modified (3) with no command when `copies_exist` is 0. When `copies_exist` is 1 it loads Shared-Modified (2) and drives `bus_cmd`=2 with `bus_data`=`cpu_wdata`.
- R5: A write hit in Exclusive or Modified moves to Modified silently. A write hit in Shared-Clean or Shared-Modified with `copies_exist`=0 also moves to Modified silently.
- R6: A write hit in Shared-Clean or Shared-Modified with `copies_exist`=1 moves to Shared-Modified and drives `bus_cmd`=2 with `bus_data`=`cpu_wdata`.
- R7: A snooped bus read (`snp_cmd`=1) moves Exclusive to Shared-Clean and Modified to Shared-Modified. Shared-Clean and Shared-Modified keep their state. Only Modified and Shared-Modified answer with `bus_cmd`=3 (flush).
- R8: A snooped bus update (`snp_cmd`=2) in Shared-Clean or Shared-Modified raises `upd_we` with `upd_data`=`snp_data` and leaves the line in Shared-Clean. Such a snoop never arrives while the line is Exclusive or Modified.
- R9: In a cycle with `snp_vld`=1, processor inputs and the fill strobe are ignored. The result is that of the snoop alone.
- R10: A read hit or a snooped flush changes no state and issues no command.
- R11: `bus_data` is 0 unless a bus update is issued, and `upd_data` is 0 unless `upd_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Processor read hit on the resident line |
| cpu_wr | input | 1 | Processor write hit on the resident line |
| cpu_wdata | input | WORD_W | Word written by the processor |
| cpu_rd_miss | input | 1 | Processor read miss, requests a bus read |
| fill_vld | input | 1 | A newly loaded block is installed this cycle |
| fill_wr | input | 1 | The fill was caused by a write miss |
| copies_exist | input | 1 | Wired line: another cache holds a copy |
| snp_vld | input | 1 | A snooped transaction is present |
| snp_cmd | input | 2 | Snooped command (1 read, 2 update, 3 flush) |
| snp_data | input | WORD_W | Word carried by a snooped update |
| bus_cmd | output | 2 | Command issued (0 none, 1 read, 2 update, 3 flush) |
| bus_data | output | WORD_W | Word broadcast with a bus update |
| upd_we | output | 1 | Write-enable for the local data word |
| upd_data | output | WORD_W | Word to write into the local copy |
| line_valid | output | 1 | A block has been loaded |
| line_state | output | 2 | Coherence state of the line |

## Verification
A wrong state shows up at the next transaction that depends on it. A line left in Exclusive or Shared-Clean when it should be dirty stays silent on a snooped read where it must flush. A line that wrongly reaches Modified sends no update on a later shared write, so other copies go stale without any error at this block's ports. The bench therefore puts the line into every state through fills and then applies each processor and snoop stimulus with both values of copies-exist. It checks the command in the same cycle and the state one edge later, so every state error surfaces within two cycles of the stimulus.

// File: rtl/dragon_line_pkg.sv
package dragon_line_pkg;

   typedef enum logic [1:0] {
      ST_EXCL  = 2'd0,
      ST_SHCLN = 2'd1,
      ST_SHMOD = 2'd2,
      ST_MOD   = 2'd3
   } line_st_e;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_RD    = 2'd1,
      CMD_UPD   = 2'd2,
      CMD_FLUSH = 2'd3
   } bus_cmd_e;

   localparam int unsigned NUM_STATES = 4;

endpackage

// File: rtl/dragon_line_next.sv
module dragon_line_next
   import dragon_line_pkg::*;
(
   input  logic     cur_valid,
   input  line_st_e cur_st,
   input  logic     cpu_rd,
   input  logic     cpu_wr,
   input  logic     cpu_rd_miss,
   input  logic     fill_vld,
   input  logic     fill_wr,
   input  logic     copies,
   input  logic     snp_vld,
   input  logic [1:0] snp_cmd,
   output logic     nxt_valid,
   output line_st_e nxt_st,
   output bus_cmd_e cmd,
   output logic     upd_we
);

   logic cur_shared;
   assign cur_shared = (cur_st == ST_SHCLN) || (cur_st == ST_SHMOD);

   always_comb begin
      nxt_valid = cur_valid;
      nxt_st    = cur_st;
      cmd       = CMD_NONE;
      upd_we    = 1'b0;
      if (snp_vld) begin
         if (cur_valid) begin
            case (snp_cmd)
               CMD_RD: begin
                  case (cur_st)
                     ST_EXCL:  nxt_st = ST_SHCLN;
                     ST_MOD: begin
                        nxt_st = ST_SHMOD;
                        cmd    = CMD_FLUSH;
                     end
                     ST_SHMOD: cmd = CMD_FLUSH;
                     default:  ;
                  endcase
               end
               CMD_UPD: begin
                  if (cur_shared) begin
                     nxt_st = ST_SHCLN;
                     upd_we = 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end else if (fill_vld) begin
         nxt_valid = 1'b1;
         if (fill_wr) begin
            nxt_st = copies ? ST_SHMOD : ST_MOD;
            cmd    = copies ? CMD_UPD : CMD_NONE;
         end else begin
            nxt_st = copies ? ST_SHCLN : ST_EXCL;
         end
      end else if (cpu_rd_miss) begin
         cmd = CMD_RD;
      end else if (cpu_wr && cur_valid) begin
         if (cur_shared && copies) begin
            nxt_st = ST_SHMOD;
            cmd    = CMD_UPD;
         end else begin
            nxt_st = ST_MOD;
         end
      end else if (cpu_rd) begin
         nxt_st = cur_st;
      end
   end

endmodule

// File: rtl/dragon_line_streg.sv
module dragon_line_streg
   import dragon_line_pkg::*;
#(
   parameter bit ONEHOT = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     nxt_valid,
   input  line_st_e nxt_st,
   output logic     cur_valid,
   output line_st_e cur_st
);

   localparam int unsigned OH_W = NUM_STATES;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_valid <= 1'b0;
      else        cur_valid <= nxt_valid;
   end

   generate
      if (ONEHOT) begin : g_onehot
         logic [OH_W-1:0] oh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oh_q <= OH_W'(1);
            else        oh_q <= OH_W'(1) << nxt_st;
         end
         always_comb begin
            cur_st = ST_EXCL;
            for (int i = 0; i < OH_W; i++) begin
               if (oh_q[i]) cur_st = line_st_e'(i);
            end
         end
      end else begin : g_binary
         line_st_e st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= ST_EXCL;
            else        st_q <= nxt_st;
         end
         assign cur_st = st_q;
      end
   endgenerate

endmodule

// File: rtl/dragon_line_datapath.sv
module dragon_line_datapath
   import dragon_line_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  bus_cmd_e           cmd,
   input  logic               upd_we,
   input  logic [WORD_W-1:0]  cpu_wdata,
   input  logic [WORD_W-1:0]  snp_data,
   output logic [WORD_W-1:0]  bus_data,
   output logic [WORD_W-1:0]  upd_data
);

   assign bus_data = (cmd == CMD_UPD) ? cpu_wdata : '0;
   assign upd_data = upd_we ? snp_data : '0;

endmodule

// File: rtl/dragon_line_ctrl.sv
module dragon_line_ctrl
   import dragon_line_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter bit          ONEHOT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [WORD_W-1:0] cpu_wdata,
   input  logic              cpu_rd_miss,
   input  logic              fill_vld,
   input  logic              fill_wr,
   input  logic              copies_exist,
   input  logic              snp_vld,
   input  logic [1:0]        snp_cmd,
   input  logic [WORD_W-1:0] snp_data,
   output logic [1:0]        bus_cmd,
   output logic [WORD_W-1:0] bus_data,
   output logic              upd_we,
   output logic [WORD_W-1:0] upd_data,
   output logic              line_valid,
   output logic [1:0]        line_state
);

   generate
      if (WORD_W < 1) begin : g_bad_width
         $error("dragon_line_ctrl: WORD_W must be at least 1");
      end
   endgenerate

   logic     cur_valid, nxt_valid;
   line_st_e cur_st, nxt_st;
   bus_cmd_e cmd;

   dragon_line_next next_i (
      .cur_valid   (cur_valid),
      .cur_st      (cur_st),
      .cpu_rd      (cpu_rd),
      .cpu_wr      (cpu_wr),
      .cpu_rd_miss (cpu_rd_miss),
      .fill_vld    (fill_vld),
      .fill_wr     (fill_wr),
      .copies      (copies_exist),
      .snp_vld     (snp_vld),
      .snp_cmd     (snp_cmd),
      .nxt_valid   (nxt_valid),
      .nxt_st      (nxt_st),
      .cmd         (cmd),
      .upd_we      (upd_we)
   );

   dragon_line_streg #(.ONEHOT(ONEHOT)) streg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .nxt_valid (nxt_valid),
      .nxt_st    (nxt_st),
      .cur_valid (cur_valid),
      .cur_st    (cur_st)
   );

   dragon_line_datapath #(.WORD_W(WORD_W)) dp_i (
      .cmd       (cmd),
      .upd_we    (upd_we),
      .cpu_wdata (cpu_wdata),
      .snp_data  (snp_data),
      .bus_data  (bus_data),
      .upd_data  (upd_data)
   );

   assign bus_cmd    = cmd;
   assign line_valid = cur_valid;
   assign line_state = cur_st;

endmodule

// File: rtl/dragon_line_ctrl_chk.sv
module dragon_line_ctrl_chk
   import dragon_line_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_rd_miss,
   input logic       fill_vld,
   input logic       copies_exist,
   input logic       snp_vld,
   input logic [1:0] snp_cmd,
   input logic [1:0] bus_cmd,
   input logic       upd_we,
   input logic       line_valid,
   input logic [1:0] line_state
);

   // R1: an unloaded line stays quiet towards the bus except for read misses
   p_quiet_unloaded_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_valid && !fill_vld) |-> (!upd_we && (bus_cmd == CMD_NONE || bus_cmd == CMD_RD)));

   // R2: a bus read is only ever caused by a read miss with no snoop or fill
   p_rd_only_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_RD) |-> (cpu_rd_miss && !snp_vld && !fill_vld));

   // R5: Modified is reached from a non-exclusive state only without other copies
   p_mod_no_copies_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (line_valid && line_state == ST_MOD &&
       !($past(line_valid) && ($past(line_state) == ST_MOD || $past(line_state) == ST_EXCL)))
      |-> !$past(copies_exist));

   // R6: every update broadcast leaves the line Shared-Modified
   p_upd_lands_shmod_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_UPD) |=> (line_valid && line_state == ST_SHMOD));

   // R7: a flush only answers a snooped read on a dirty line
   p_flush_dirty_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_FLUSH) |-> (line_valid && snp_vld && snp_cmd == CMD_RD &&
                                  (line_state == ST_MOD || line_state == ST_SHMOD)));

   // R8: an applied update leaves the line Shared-Clean
   p_upd_we_shcln_r8: assert property (@(posedge clk) disable iff (!rst_n)
      upd_we |=> (line_valid && line_state == ST_SHCLN));

   // R8: no update is snooped while the line is a sole copy
   p_no_upd_sole_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_vld && snp_cmd == CMD_UPD && line_valid) |->
      (line_state == ST_SHCLN || line_state == ST_SHMOD));

endmodule

bind dragon_line_ctrl dragon_line_ctrl_chk chk_i (.*);

// File: tb/dragon_line_ctrl_tb_top.sv
module dragon_line_ctrl_tb_top;

   localparam int W = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n, cpu_rd, cpu_wr, cpu_rd_miss, fill_vld, fill_wr, copies_exist, snp_vld;
   logic [W-1:0] cpu_wdata, snp_data;
   logic [1:0]   snp_cmd;
   logic [1:0]   bus_cmd, line_state;
   logic [W-1:0] bus_data, upd_data;
   logic         upd_we, line_valid;

   dragon_line_ctrl #(.WORD_W(W), .ONEHOT(1'b1)) dut_i (.*);

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      cpu_rd = 0; cpu_wr = 0; cpu_rd_miss = 0; fill_vld = 0; fill_wr = 0;
      snp_vld = 0; snp_cmd = 0;
   endtask

   // drive at negedge, check combinational outputs before the edge, state after it
   task automatic cycle(input string req, input int e_cmd, input int e_bdata, input bit e_we,
                        input int e_udata, input bit e_valid, input int e_state, input bit chk_state);
      #2;
      chk(bus_cmd == 2'(e_cmd), req, bus_cmd, e_cmd);
      chk(bus_data == W'(e_bdata), {req, " data"}, bus_data, e_bdata);
      chk(upd_we == e_we, req, upd_we, e_we);
      chk(upd_data == W'(e_udata), {req, " upd"}, upd_data, e_udata);
      @(posedge clk); #1;
      chk(line_valid == e_valid, req, line_valid, e_valid);
      if (chk_state) chk(line_state == 2'(e_state), req, line_state, e_state);
      idle_inputs();
   endtask

   task automatic fill_to(input int s, input int wd);
      @(negedge clk);
      fill_vld = 1; fill_wr = (s >= 2); copies_exist = (s == 1 || s == 2); cpu_wdata = W'(wd);
      if (s < 2) cycle("R3 read fill", 0, 0, 0, 0, 1, s, 1);
      else cycle("R4 write fill", (s == 2) ? 2 : 0, (s == 2) ? wd : 0, 0, 0, 1, s, 1);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      idle_inputs(); copies_exist = 0; cpu_wdata = 0; snp_data = 0; rst_n = 0;
      repeat (2) @(negedge clk);
      // R1 reset state
      chk(line_valid == 0, "R1 reset valid", line_valid, 0);
      chk(bus_cmd == 0, "R1 reset cmd", bus_cmd, 0);
      chk(upd_we == 0, "R1 reset we", upd_we, 0);
      rst_n = 1;

      // R1 unloaded line ignores snoops and hits
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         copies_exist = 1; cpu_wdata = 8'h5A; snp_data = 8'hC3;
         case (k)
            0: begin snp_vld = 1; snp_cmd = 1; end
            1: begin snp_vld = 1; snp_cmd = 2; end
            2: begin snp_vld = 1; snp_cmd = 3; end
            3: cpu_wr = 1;
            default: cpu_rd = 1;
         endcase
         cycle("R1 unloaded", 0, 0, 0, 0, 0, 0, 0);
      end
      // R2 read miss on an unloaded line
      @(negedge clk); cpu_rd_miss = 1;
      cycle("R2 miss unloaded", 1, 0, 0, 0, 0, 0, 0);

      // sweep: every state x every stimulus x copies-exist x data pattern
      for (int s = 0; s < 4; s++) begin
         for (int op = 0; op < 7; op++) begin
            for (int c = 0; c < 2; c++) begin
               for (int d = 0; d < 2; d++) begin
                  int wd, sd, e_cmd, e_st, e_bd, e_ud;
                  bit e_we;
                  string req;
                  if (op == 4 && (s == 0 || s == 3)) continue;
                  wd = d ? (8'hA5 ^ s) : (8'h3C + op);
                  sd = ~wd & 8'hFF;
                  fill_to(s, wd);
                  @(negedge clk);
                  copies_exist = c[0]; cpu_wdata = W'(wd); snp_data = W'(sd);
                  e_cmd = 0; e_st = s; e_we = 0; e_bd = 0; e_ud = 0;
                  case (op)
                     0: begin cpu_rd = 1; req = "R10 read hit"; end
                     1: begin
                        cpu_wr = 1;
                        if ((s == 1 || s == 2) && c == 1) begin
                           e_st = 2; e_cmd = 2; e_bd = wd; req = "R6 shared write";
                        end else begin
                           e_st = 3; req = "R5 silent write";
                        end
                     end
                     2: begin cpu_rd_miss = 1; e_cmd = 1; req = "R2 read miss"; end
                     3, 6: begin
                        snp_vld = 1; snp_cmd = 1;
                        if (op == 6) begin cpu_wr = 1; fill_vld = 1; req = "R9 snoop priority"; end
                        else req = "R7 snoop read";
                        if (s == 0) e_st = 1;
                        if (s == 3) e_st = 2;
                        if (s >= 2) e_cmd = 3;
                     end
                     4: begin
                        snp_vld = 1; snp_cmd = 2; e_st = 1; e_we = 1; e_ud = sd;
                        req = "R8 snoop update";
                     end
                     default: begin snp_vld = 1; snp_cmd = 3; req = "R10 snoop flush"; end
                  endcase
                  cycle(req, e_cmd, e_bd, e_we, e_ud, 1, e_st, 1);
               end
            end
         end
      end

      // R11: data outputs stay zero when idle with live data inputs
      @(negedge clk); cpu_wdata = 8'hFF; snp_data = 8'hFF;
      cycle("R11 idle data", 0, 0, 0, 0, 1, 1, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule